// File: doc/BRIEF.md
# Lookup-Table Binary Shift-Keying Modulator

This block turns a serial stream of data bits into a sampled, keyed sine carrier. Two carrier paths each read a precomputed sine table through their own phase counter, and a two-way multiplexer picks one of them. The symbol bit that is currently held drives the multiplexer select. A mode input chooses amplitude, phase or frequency keying. It does this only by changing what the second path delivers (silence, the negated carrier, or the carrier read at a faster step). The first path is always the plain carrier.

A bit-strobe marks each symbol boundary. On the strobe the block latches the data bit and restarts both phase counters, so every symbol begins at phase zero. The output is a registered signed sample word together with a valid flag. One new sample leaves the block on every clock. The stream has no back-pressure: there is no ready input, and the downstream consumer (typically a DAC interface) must accept a sample each cycle while the valid flag is high.

Top module: `shift_key_mod`

## Requirements
- R1: While reset (rst_n low) is applied, sample_o is 0 and sample_valid_o is 0.
- R2: sample_valid_o rises at the first clock edge after reset is released and then stays high until the next reset.
- R3: The carrier table holds 64 entries. Entry k is round(127 * sin(2*pi*k/64)) as 8-bit two's complement, so the peak at entry 16 is +127 and the trough at entry 48 is -127. The output is never -128.
- R4: When bit_strobe_i is high at a clock edge E, data_bit_i is latched as the symbol bit and both phase counters go to 0. The sample visible after edge E+1+k corresponds to phase index k of the new symbol.
- R5: When bit_strobe_i is low, data_bit_i has no effect: the held symbol bit, and therefore the output waveform, does not change.
- R6: With symbol bit 1 in modes 2'b00, 2'b01 and 2'b10, the output is the carrier table read one entry per clock: sample k = table[k mod 64].
- R7: Mode 2'b00 (amplitude keying): with symbol bit 0 the output is 0.
- R8: Mode 2'b01 (phase keying): with symbol bit 0 the output is the two's-complement negation of the carrier, sample k = -table[k mod 64]. A bit-1 symbol therefore starts with positive samples and a bit-0 symbol starts with negative samples.
- R9: Mode 2'b10 (frequency keying): with symbol bit 0 the second path steps two entries per clock, sample k = table[(2k) mod 64], which doubles the frequency with the same amplitude.
- R10: Mode 2'b11 forces the output to 0 whatever the symbol bit is.
- R11: The output is registered. The sample after edge E+1 following a strobe at E is the phase-0 value, which is 0 in every mode, and the sample after E+2 is the phase-1 value.
- R12: Both phase counters wrap modulo 64, so sample k+64 equals sample k within one symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Keying mode: 00 amplitude, 01 phase, 10 frequency, 11 silent |
| data_bit_i | input | 1 | Serial data bit, sampled only on a strobe |
| bit_strobe_i | input | 1 | Symbol boundary: latch data bit and restart phase |
| sample_o | output | 8 | Signed output sample |
| sample_valid_o | output | 1 | Output sample is valid (high whenever out of reset) |

## Verification
Some properties are checked on every clock. The valid flag stays high once it has risen. The silent mode and amplitude keying with a zero symbol give a zero sample one edge later. A zero sample always appears two edges after a strobe. The output never takes the most negative code. The exact waveform shapes can only be shown by the bench's scenarios, which compare every sample against an independently computed sine: the negated carrier in phase keying, the doubled step in frequency keying, the wrap after 64 entries, and the data bit being ignored mid-symbol.

// File: rtl/skm_pkg.sv
package skm_pkg;
  typedef enum logic [1:0] {
    KEY_AMP   = 2'b00,
    KEY_PHASE = 2'b01,
    KEY_FREQ  = 2'b10,
    KEY_OFF   = 2'b11
  } key_mode_e;

  localparam real TWO_PI = 6.283185307179586;
endpackage

// File: rtl/skm_phase_acc.sv
module skm_phase_acc #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [IDX_W-1:0] step_i,
  output logic [IDX_W-1:0] idx_o
);
  // natural wrap of the IDX_W-bit sum gives modulo-depth stepping
  always_ff @(posedge clk) begin
    if (!rst_n)         idx_o <= '0;
    else if (restart_i) idx_o <= '0;
    else                idx_o <= idx_o + step_i;
  end
endmodule

// File: rtl/skm_sine_lut.sv
module skm_sine_lut #(
  parameter int IDX_W    = 6,
  parameter int SAMPLE_W = 8,
  parameter int PEAK     = 127
) (
  input  logic [IDX_W-1:0]           idx_i,
  output logic signed [SAMPLE_W-1:0] value_o
);
  import skm_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  typedef logic signed [SAMPLE_W-1:0] lut_t [DEPTH];

  function automatic lut_t build_lut();
    lut_t t;
    real  a;
    for (int i = 0; i < DEPTH; i++) begin
      a = real'(PEAK) * $sin(TWO_PI * real'(i) / real'(DEPTH));
      t[i] = SAMPLE_W'((a >= 0.0) ? $rtoi(a + 0.5) : $rtoi(a - 0.5));
    end
    return t;
  endfunction

  localparam lut_t TABLE = build_lut();

  assign value_o = TABLE[idx_i];
endmodule

// File: rtl/skm_space_shaper.sv
module skm_space_shaper #(
  parameter int SAMPLE_W = 8
) (
  input  skm_pkg::key_mode_e         mode_i,
  input  logic signed [SAMPLE_W-1:0] raw_i,
  output logic signed [SAMPLE_W-1:0] shaped_o
);
  import skm_pkg::*;

  always_comb begin
    unique case (mode_i)
      KEY_PHASE: shaped_o = -raw_i;
      KEY_FREQ:  shaped_o = raw_i;
      default:   shaped_o = '0;
    endcase
  end
endmodule

// File: rtl/shift_key_mod.sv
module shift_key_mod #(
  parameter int IDX_W    = 6,
  parameter int SAMPLE_W = 8,
  parameter int PEAK     = 127,
  parameter int FSK_STEP = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode_i,
  input  logic                       data_bit_i,
  input  logic                       bit_strobe_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       sample_valid_o
);
  import skm_pkg::*;

  localparam int NPATH = 2;

  key_mode_e mode;
  assign mode = key_mode_e'(mode_i);

  logic sym_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)            sym_bit <= 1'b0;
    else if (bit_strobe_i) sym_bit <= data_bit_i;
  end

  logic [IDX_W-1:0]           step  [NPATH];
  logic [IDX_W-1:0]           idx   [NPATH];
  logic signed [SAMPLE_W-1:0] lut_v [NPATH];

  assign step[0] = IDX_W'(1);
  assign step[1] = (mode == KEY_FREQ) ? IDX_W'(FSK_STEP) : IDX_W'(1);

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    skm_phase_acc #(.IDX_W(IDX_W)) i_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (bit_strobe_i),
      .step_i    (step[p]),
      .idx_o     (idx[p])
    );
    skm_sine_lut #(.IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W), .PEAK(PEAK)) i_lut (
      .idx_i   (idx[p]),
      .value_o (lut_v[p])
    );
  end

  logic signed [SAMPLE_W-1:0] space_v;

  skm_space_shaper #(.SAMPLE_W(SAMPLE_W)) i_shape (
    .mode_i   (mode),
    .raw_i    (lut_v[1]),
    .shaped_o (space_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else begin
      sample_valid_o <= 1'b1;
      if (mode == KEY_OFF) sample_o <= '0;
      else                 sample_o <= sym_bit ? lut_v[0] : space_v;
    end
  end
endmodule

// File: rtl/skm_chk.sv
module skm_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 mode_i,
  input logic                       bit_strobe_i,
  input logic                       sym_bit,
  input logic signed [SAMPLE_W-1:0] sample_o,
  input logic                       sample_valid_o
);
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |=> sample_valid_o);

  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> (sample_o == '0));

  // R7
  ask_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !sym_bit) |=> (sample_o == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |-> (sample_o != MOST_NEG));

  // R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe_i |-> ##2 (sample_o == '0));
endmodule

bind shift_key_mod skm_chk #(.SAMPLE_W(SAMPLE_W)) i_skm_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_i         (mode_i),
  .bit_strobe_i   (bit_strobe_i),
  .sym_bit        (sym_bit),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o)
);

// File: tb/test_shift_key_mod.sv
module test_shift_key_mod;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode = 2'b00;
  logic             data_bit = 1'b0;
  logic             strobe = 1'b0;
  logic signed [7:0] sample;
  logic             valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  shift_key_mod i_shift_key_mod (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode),
    .data_bit_i     (data_bit),
    .bit_strobe_i   (strobe),
    .sample_o       (sample),
    .sample_valid_o (valid)
  );

  function automatic int tbl(int k);
    real a;
    a = 127.0 * $sin(6.283185307179586 * real'(k % 64) / 64.0);
    return (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
  endfunction

  function automatic int expect_of(logic [1:0] m, logic b, int k);
    if (m == 2'b11) return 0;
    if (b)          return tbl(k);
    case (m)
      2'b00:   return 0;
      2'b01:   return -tbl(k);
      default: return tbl(2 * k);
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {mode, bit}
  localparam logic [2:0] VEC [8] = '{3'b001, 3'b000, 3'b011, 3'b010,
                                     3'b101, 3'b100, 3'b111, 3'b110};
  localparam int NSAMP = 70;

  task automatic start_symbol(logic b);
    @(negedge clk);
    data_bit = b;
    strobe   = 1'b1;
    @(negedge clk);
    strobe   = 1'b0;
    data_bit = ~b;  // R5: toggled without strobe, must be ignored
  endtask

  function automatic string tag_of(logic [1:0] m, logic b, int k);
    if (k == 0)     return "R4";
    if (k == 1)     return "R11";
    if (k >= 64)    return "R12";
    if (m == 2'b11) return "R10";
    if (b)          return "R6";
    case (m)
      2'b00:   return "R7";
      2'b01:   return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sample", int'(sample), 0);
    check("R1 valid", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 valid", int'(valid), 1);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] m;
      logic       b;
      m = VEC[v][2:1];
      b = VEC[v][0];
      @(negedge clk);
      mode = m;
      start_symbol(b);
      for (int k = 0; k < NSAMP; k++) begin
        @(negedge clk);
        check(tag_of(m, b, k), int'(sample), expect_of(m, b, k));
      end
    end

    // R3 peak and trough, R5 data ignored without strobe
    mode = 2'b00;
    start_symbol(1'b1);
    for (int k = 0; k <= 48; k++) begin
      @(negedge clk);
      if (k == 16) check("R3 peak", int'(sample), 127);
      if (k == 20) data_bit = 1'b0;
      if (k == 48) check("R3 trough", int'(sample), -127);
    end
    check("R5 bit held", int'(sample), -127);

    // R8 polarity at start of symbols
    mode = 2'b01;
    start_symbol(1'b0);
    repeat (3) @(negedge clk);
    check("R8 bit0 starts negative", int'(sample < 0), 1);
    start_symbol(1'b1);
    repeat (3) @(negedge clk);
    check("R8 bit1 starts positive", int'(sample > 0), 1);

    // R2 valid held; R1 reset mid-run
    check("R2 valid held", int'(valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 sample in reset", int'(sample), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 valid after reset", int'(valid), 1);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule